// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It walks a page directory and, for small pages, a page table, both held in memory. A requester presents the address with a write flag, a user-mode flag, the directory frame number and a write-protect enable. The walker then reads entries over a single request/acknowledge memory port, one transaction at a time. When an entry's accessed bit is clear, the walker sets it and writes the entry back. When a permitted write reaches a leaf whose dirty bit is clear, the walker sets that bit and writes the leaf back. The walk ends with a one-cycle `done` pulse and the physical address, or with a one-cycle `fault` pulse, a 3-bit error code and the captured faulting address.

Directory entries with the page-size flag set map 4 MB pages directly. Other directory entries point at a page table that maps 4 KB pages. Access rights come from a 5-bit index into a fixed 32-bit grant mask. The write-protect enable forms the top bit of that index.

States: `ST_IDLE` (wait for request), `ST_DIR_RD` (fetch directory entry), `ST_DIR_ACC` (write back directory entry with accessed set), `ST_TBL_RD` (fetch table entry), `ST_TBL_ACC` (write back table entry with accessed set), `ST_PERM` (rights check and address build), `ST_LEAF_DIRTY` (write back leaf with dirty set), `ST_DONE` (success pulse), `ST_FAULT` (fault pulse). Transitions:
- idle→dir_rd on a request.
- dir_rd→fault when not present.
- dir_rd→dir_acc when accessed is clear.
- dir_rd or dir_acc→perm on a large page.
- dir_rd or dir_acc→tbl_rd on a small page.
- tbl_rd→fault when not present.
- tbl_rd→tbl_acc when accessed is clear.
- tbl_rd or tbl_acc→perm.
- perm→fault when rights are denied.
- perm→leaf_dirty on a write to a clean leaf.
- perm→done otherwise.
- leaf_dirty→done.
- done and fault→idle.

Top module: `pt_walker`

## Requirements
- R1: The directory entry is read from address {dir_frame, laddr[31:22], 2'b00}.
- R2: A directory entry with bit 0 (present) clear ends the walk with `fault`, error bit 0 = 0, and no further memory transaction.
- R3: For a directory entry with bit 7 clear, the table entry is read from {pde[31:12], laddr[21:12], 2'b00}, and `paddr` = {pte[31:12], laddr[11:0]}.
- R4: For a directory entry with bit 7 set, no table entry is read, and `paddr` = {pde[31:22], laddr[21:0]}.
- R5: A table entry with bit 0 clear ends the walk with `fault` and error bit 0 = 0.
- R6: A directory entry read with bit 5 (accessed) clear is written back to the same address with bit 5 set before the walk continues.
- R7: A table entry read with bit 5 clear is written back to the same address with bit 5 set before the rights check.
- R8: Access rights use W = pde[1] & leaf[1] and U = pde[2] & leaf[2]; for a large page, pde is the leaf. A supervisor access is granted unless it is a write with write-protect on and W = 0. A user access needs U = 1 and, for a write, W = 1. This equals bit {wp, user, U, W, write} of 0xD0DDD0FF.
- R9: A rights failure gives `fault` with error bit 0 = 1. Every fault gives error bit 1 = write flag, error bit 2 = user flag, and `fault_addr` = the requested linear address.
- R10: A granted write to a leaf with bit 6 (dirty) clear writes the leaf back with bit 6 set. A read, a set dirty bit, or a denied write writes nothing.
- R11: One memory transaction is outstanding at a time, and the request and address are held until acknowledged. `done` and `fault` are one-cycle pulses. Requests presented while a walk is in progress, including its final cycle, are ignored.
- R12: After reset the walker is idle with `mem_req`, `done` and `fault` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a walk (taken only when idle) |
| req_laddr | input | 32 | Linear address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| dir_frame | input | 20 | Page directory frame number (physical address bits 31:12) |
| wp_en | input | 1 | Supervisor write-protect enable |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | Transaction is a write |
| mem_addr | output | 32 | Entry address |
| mem_wdata | output | 32 | Entry value to write |
| mem_ack | input | 1 | Transaction complete |
| mem_rdata | input | 32 | Entry value read, valid with mem_ack |
| done | output | 1 | Translation finished (pulse) |
| fault | output | 1 | Page fault (pulse) |
| paddr | output | 32 | Physical address, valid at done |
| fault_code | output | 3 | {user, write, protection} |
| fault_addr | output | 32 | Faulting linear address |

## Verification
The rights decision and the dirty update are settled in the same state, so a write to a clean leaf that is not writable must fault without any write-back. The bench provokes this with write-protect on and a clean read-only table entry. It judges the result by the fault code and by a count of zero memory writes. A second overlap is a new request arriving during the final cycle of a walk. The bench holds a different request valid throughout a walk, including the `done` cycle. It then checks that exactly one `done` appears, carrying the first address's translation, and that only two memory transactions took place.

// File: rtl/pt_pkg.sv
package pt_pkg;

    // Entry bit positions (decoded by the walker and its neighbours)
    localparam int E_PRESENT  = 0;
    localparam int E_WRITE    = 1;
    localparam int E_USER     = 2;
    localparam int E_ACCESSED = 5;
    localparam int E_DIRTY    = 6;
    localparam int E_PAGESIZE = 7;

    localparam int ERR_W = 3;

    localparam logic [31:0] GRANT_MASK = 32'hD0DDD0FF;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DIR_RD,
        ST_DIR_ACC,
        ST_TBL_RD,
        ST_TBL_ACC,
        ST_PERM,
        ST_LEAF_DIRTY,
        ST_DONE,
        ST_FAULT
    } walk_state_e;

endpackage

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
    parameter int AW         = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int DIR_SHIFT  = 22
) (
    input  logic [AW-PAGE_SHIFT-1:0] dir_frame,
    input  logic [AW-1:0]            lin,
    input  logic [AW-1:PAGE_SHIFT]   pde_hi,
    input  logic [AW-1:PAGE_SHIFT]   pte_hi,
    output logic [AW-1:0]            pde_addr,
    output logic [AW-1:0]            pte_addr,
    output logic [AW-1:0]            small_pa,
    output logic [AW-1:0]            large_pa
);
    localparam int WORD_BITS = PAGE_SHIFT - (AW - DIR_SHIFT);

    always_comb begin
        pde_addr = {dir_frame, lin[AW-1:DIR_SHIFT], {WORD_BITS{1'b0}}};
        pte_addr = {pde_hi, lin[DIR_SHIFT-1:PAGE_SHIFT], {WORD_BITS{1'b0}}};
        small_pa = {pte_hi, lin[PAGE_SHIFT-1:0]};
        large_pa = {pde_hi[AW-1:DIR_SHIFT], lin[DIR_SHIFT-1:0]};
    end
endmodule

// File: rtl/pt_perm_check.sv
module pt_perm_check #(
    parameter logic [31:0] MASK    = 32'hD0DDD0FF,
    parameter bit          USE_LUT = 1'b1
) (
    input  logic is_write,
    input  logic is_user,
    input  logic wp,
    input  logic dir_w,
    input  logic dir_u,
    input  logic leaf_w,
    input  logic leaf_u,
    output logic grant
);
    logic eff_w;
    logic eff_u;

    assign eff_w = dir_w & leaf_w;
    assign eff_u = dir_u & leaf_u;

    generate
        if (USE_LUT) begin : g_lut
            logic [4:0] idx;
            assign idx   = {wp, is_user, eff_u, eff_w, is_write};
            assign grant = MASK[idx];
        end else begin : g_logic
            assign grant = is_user ? (eff_u & (~is_write | eff_w))
                                   : (~is_write | ~wp | eff_w);
        end
    endgenerate
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_pkg::*;
#(
    parameter int AW         = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int DIR_SHIFT  = 22,
    parameter bit USE_LUT    = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [AW-1:0]            req_laddr,
    input  logic                     req_write,
    input  logic                     req_user,
    input  logic [AW-PAGE_SHIFT-1:0] dir_frame,
    input  logic                     wp_en,
    output logic                     mem_req,
    output logic                     mem_we,
    output logic [AW-1:0]            mem_addr,
    output logic [AW-1:0]            mem_wdata,
    input  logic                     mem_ack,
    input  logic [AW-1:0]            mem_rdata,
    output logic                     done,
    output logic                     fault,
    output logic [AW-1:0]            paddr,
    output logic [ERR_W-1:0]         fault_code,
    output logic [AW-1:0]            fault_addr
);
    localparam logic [AW-1:0] ACC_BIT   = {{(AW-1){1'b0}}, 1'b1} << E_ACCESSED;
    localparam logic [AW-1:0] DIRTY_BIT = {{(AW-1){1'b0}}, 1'b1} << E_DIRTY;

    walk_state_e             state;
    logic [AW-1:0]           lin_q;
    logic                    wr_q;
    logic                    usr_q;
    logic                    wp_q;
    logic [AW-PAGE_SHIFT-1:0] frame_q;
    logic [AW-1:0]           pde_q;
    logic [AW-1:0]           pte_q;
    logic                    large_q;
    logic [AW-1:0]           paddr_q;
    logic [ERR_W-1:0]        fcode_q;
    logic [AW-1:0]           faddr_q;

    logic [AW-1:0] pde_addr;
    logic [AW-1:0] pte_addr;
    logic [AW-1:0] small_pa;
    logic [AW-1:0] large_pa;
    logic [AW-1:0] leaf;
    logic          grant;

    assign leaf = large_q ? pde_q : pte_q;

    pt_addr_gen #(
        .AW(AW), .PAGE_SHIFT(PAGE_SHIFT), .DIR_SHIFT(DIR_SHIFT)
    ) u_addr (
        .dir_frame (frame_q),
        .lin       (lin_q),
        .pde_hi    (pde_q[AW-1:PAGE_SHIFT]),
        .pte_hi    (pte_q[AW-1:PAGE_SHIFT]),
        .pde_addr  (pde_addr),
        .pte_addr  (pte_addr),
        .small_pa  (small_pa),
        .large_pa  (large_pa)
    );

    pt_perm_check #(
        .MASK(GRANT_MASK), .USE_LUT(USE_LUT)
    ) u_perm (
        .is_write (wr_q),
        .is_user  (usr_q),
        .wp       (wp_q),
        .dir_w    (pde_q[E_WRITE]),
        .dir_u    (pde_q[E_USER]),
        .leaf_w   (leaf[E_WRITE]),
        .leaf_u   (leaf[E_USER]),
        .grant    (grant)
    );

    // State register and walk data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            lin_q   <= '0;
            wr_q    <= 1'b0;
            usr_q   <= 1'b0;
            wp_q    <= 1'b0;
            frame_q <= '0;
            pde_q   <= '0;
            pte_q   <= '0;
            large_q <= 1'b0;
            paddr_q <= '0;
            fcode_q <= '0;
            faddr_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        lin_q   <= req_laddr;
                        wr_q    <= req_write;
                        usr_q   <= req_user;
                        wp_q    <= wp_en;
                        frame_q <= dir_frame;
                        large_q <= 1'b0;
                        state   <= ST_DIR_RD;
                    end
                end
                ST_DIR_RD: begin
                    if (mem_ack) begin
                        pde_q <= mem_rdata | ACC_BIT;
                        if (!mem_rdata[E_PRESENT]) begin
                            fcode_q <= {usr_q, wr_q, 1'b0};
                            faddr_q <= lin_q;
                            state   <= ST_FAULT;
                        end else if (!mem_rdata[E_ACCESSED]) begin
                            state <= ST_DIR_ACC;
                        end else if (mem_rdata[E_PAGESIZE]) begin
                            large_q <= 1'b1;
                            state   <= ST_PERM;
                        end else begin
                            state <= ST_TBL_RD;
                        end
                    end
                end
                ST_DIR_ACC: begin
                    if (mem_ack) begin
                        if (pde_q[E_PAGESIZE]) begin
                            large_q <= 1'b1;
                            state   <= ST_PERM;
                        end else begin
                            state <= ST_TBL_RD;
                        end
                    end
                end
                ST_TBL_RD: begin
                    if (mem_ack) begin
                        pte_q <= mem_rdata | ACC_BIT;
                        if (!mem_rdata[E_PRESENT]) begin
                            fcode_q <= {usr_q, wr_q, 1'b0};
                            faddr_q <= lin_q;
                            state   <= ST_FAULT;
                        end else if (!mem_rdata[E_ACCESSED]) begin
                            state <= ST_TBL_ACC;
                        end else begin
                            state <= ST_PERM;
                        end
                    end
                end
                ST_TBL_ACC: begin
                    if (mem_ack) begin
                        state <= ST_PERM;
                    end
                end
                ST_PERM: begin
                    if (!grant) begin
                        fcode_q <= {usr_q, wr_q, 1'b1};
                        faddr_q <= lin_q;
                        state   <= ST_FAULT;
                    end else begin
                        paddr_q <= large_q ? large_pa : small_pa;
                        if (wr_q && !leaf[E_DIRTY]) begin
                            if (large_q) pde_q <= pde_q | DIRTY_BIT;
                            else         pte_q <= pte_q | DIRTY_BIT;
                            state <= ST_LEAF_DIRTY;
                        end else begin
                            state <= ST_DONE;
                        end
                    end
                end
                ST_LEAF_DIRTY: begin
                    if (mem_ack) begin
                        state <= ST_DONE;
                    end
                end
                ST_DONE:  state <= ST_IDLE;
                ST_FAULT: state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Outputs decoded from state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        done      = 1'b0;
        fault     = 1'b0;
        unique case (state)
            ST_DIR_RD: begin
                mem_req  = 1'b1;
                mem_addr = pde_addr;
            end
            ST_DIR_ACC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = pde_addr;
                mem_wdata = pde_q;
            end
            ST_TBL_RD: begin
                mem_req  = 1'b1;
                mem_addr = pte_addr;
            end
            ST_TBL_ACC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = pte_addr;
                mem_wdata = pte_q;
            end
            ST_LEAF_DIRTY: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = large_q ? pde_addr : pte_addr;
                mem_wdata = leaf;
            end
            ST_DONE:  done  = 1'b1;
            ST_FAULT: fault = 1'b1;
            default: begin
                mem_req = 1'b0;
            end
        endcase
    end

    assign paddr      = paddr_q;
    assign fault_code = fcode_q;
    assign fault_addr = faddr_q;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R11

    AST_WB_ACCESSED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata[E_ACCESSED] && mem_wdata[E_PRESENT])); // R6

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fault) |=> (!done && !fault)); // R11

    AST_PAGE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (paddr[PAGE_SHIFT-1:0] == lin_q[PAGE_SHIFT-1:0])); // R3

    AST_FAULT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (fault_addr == lin_q)); // R9

    AST_DIRTY_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LEAF_DIRTY) |-> (wr_q && mem_wdata[E_DIRTY])); // R10
endmodule

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_laddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic [19:0] dir_frame = 20'h00100;
    logic        wp_en = 1'b0;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done;
    logic        fault;
    logic [31:0] paddr;
    logic [2:0]  fault_code;
    logic [31:0] fault_addr;

    int checks = 0;
    int fails  = 0;
    int txn_cnt = 0;
    int wr_cnt  = 0;
    bit finished = 0;

    logic [31:0] mem_model [logic [31:0]];

    always #10 clk = ~clk;

    pt_walker u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_laddr(req_laddr),
        .req_write(req_write), .req_user(req_user), .dir_frame(dir_frame),
        .wp_en(wp_en), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .done(done), .fault(fault), .paddr(paddr), .fault_code(fault_code),
        .fault_addr(fault_addr)
    );

    // Memory model: acknowledges one cycle after a request is seen
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            txn_cnt++;
            if (mem_we) begin
                mem_model[mem_addr] = mem_wdata;
                wr_cnt++;
            end else begin
                mem_rdata <= mem_model.exists(mem_addr) ? mem_model[mem_addr] : 32'h0;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem_model.exists(a) ? mem_model[a] : 32'h0;
    endfunction

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic walk(input logic [31:0] la, input bit w, input bit u, input bit wp,
                        output bit got_done, output bit got_fault);
        int n;
        txn_cnt = 0;
        wr_cnt  = 0;
        @(negedge clk);
        req_valid = 1'b1; req_laddr = la; req_write = w; req_user = u; wp_en = wp;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!(done || fault) && n < 100) begin
            @(negedge clk);
            n++;
        end
        got_done  = done;
        got_fault = fault;
        @(negedge clk);
        chk("R11 pulse", {30'd0, done, fault}, 32'd0);
    endtask

    task automatic t_reset;
        chk("R12 mem_req", {31'd0, mem_req}, 32'd0);
        chk("R12 done", {31'd0, done}, 32'd0);
        chk("R12 fault", {31'd0, fault}, 32'd0);
    endtask

    task automatic t_small_read;
        bit d, f;
        walk(32'h0040_3ABC, 1'b0, 1'b0, 1'b0, d, f);
        chk("R3 done", {30'd0, d, f}, 32'd2);
        chk("R3 paddr", paddr, 32'h0ABC_DABC);
        chk("R1 txn", txn_cnt, 2);
        chk("R10 no wb on read", wr_cnt, 0);
    endtask

    task automatic t_small_write_dirty_set;
        bit d, f;
        walk(32'h0040_3004, 1'b1, 1'b1, 1'b0, d, f);
        chk("R3 done", {30'd0, d, f}, 32'd2);
        chk("R3 paddr", paddr, 32'h0ABC_D004);
        chk("R10 no wb dirty set", wr_cnt, 0);
    endtask

    task automatic t_accessed_wb;
        bit d, f;
        walk(32'h0080_1010, 1'b0, 1'b0, 1'b0, d, f);
        chk("R6 done", {30'd0, d, f}, 32'd2);
        chk("R6 pde", rd(32'h0010_0008), 32'h0030_0027);
        chk("R7 pte", rd(32'h0030_0004), 32'h0555_5027);
        chk("R7 writes", wr_cnt, 2);
        chk("R3 paddr", paddr, 32'h0555_5010);
        walk(32'h0080_1020, 1'b1, 1'b0, 1'b0, d, f);
        chk("R10 done", {30'd0, d, f}, 32'd2);
        chk("R10 writes", wr_cnt, 1);
        chk("R10 pte", rd(32'h0030_0004), 32'h0555_5067);
    endtask

    task automatic t_large;
        bit d, f;
        walk(32'h0C12_3456, 1'b0, 1'b1, 1'b0, d, f);
        chk("R4 done", {30'd0, d, f}, 32'd2);
        chk("R4 paddr", paddr, 32'h1F92_3456);
        chk("R4 txn", txn_cnt, 1);
        walk(32'h0C00_0010, 1'b1, 1'b1, 1'b0, d, f);
        chk("R4 paddr wr", paddr, 32'h1F80_0010);
        chk("R10 large writes", wr_cnt, 1);
        chk("R10 large pde", rd(32'h0010_00C0), 32'h1F80_00E7);
    endtask

    task automatic t_dir_absent;
        bit d, f;
        walk(32'hFFC0_0123, 1'b1, 1'b1, 1'b0, d, f);
        chk("R2 fault", {30'd0, d, f}, 32'd1);
        chk("R2 code", {29'd0, fault_code}, 32'd6);
        chk("R9 addr", fault_addr, 32'hFFC0_0123);
        chk("R2 txn", txn_cnt, 1);
    endtask

    task automatic t_tbl_absent;
        bit d, f;
        walk(32'h0040_5678, 1'b0, 1'b0, 1'b0, d, f);
        chk("R5 fault", {30'd0, d, f}, 32'd1);
        chk("R5 code", {29'd0, fault_code}, 32'd0);
        chk("R9 addr", fault_addr, 32'h0040_5678);
        chk("R5 txn", txn_cnt, 2);
    endtask

    task automatic t_clean_readonly_write;
        bit d, f;
        walk(32'h0040_6008, 1'b1, 1'b0, 1'b1, d, f);
        chk("R8 wp fault", {30'd0, d, f}, 32'd1);
        chk("R9 code", {29'd0, fault_code}, 32'd3);
        chk("R10 no dirty on deny", wr_cnt, 0);
    endtask

    task automatic t_perm_sweep;
        bit d, f, ok;
        bit ew, eu;
        for (int pf = 0; pf < 4; pf++) begin
            for (int tf = 0; tf < 4; tf++) begin
                for (int m = 0; m < 8; m++) begin
                    mem_model[32'h0010_0010] = 32'h0040_0021 | (32'(pf) << 1);
                    mem_model[32'h0040_0000] = 32'h0060_0061 | (32'(tf) << 1);
                    ew = pf[0] & tf[0];
                    eu = pf[1] & tf[1];
                    if (m[1]) ok = eu && (!m[0] || ew);
                    else      ok = !m[0] || !m[2] || ew;
                    walk(32'h0100_0234, m[0], m[1], m[2], d, f);
                    chk("R8 outcome", {30'd0, d, f}, ok ? 32'd2 : 32'd1);
                    if (ok) chk("R8 paddr", paddr, 32'h0060_0234);
                    else    chk("R9 code", {29'd0, fault_code}, {29'd0, m[1], m[0], 1'b1});
                end
            end
        end
    endtask

    task automatic t_busy_ignore;
        int n;
        int dn;
        txn_cnt = 0;
        @(negedge clk);
        req_valid = 1'b1; req_laddr = 32'h0040_3ABC; req_write = 1'b0; req_user = 1'b0; wp_en = 1'b0;
        @(negedge clk);
        req_laddr = 32'h0080_1010;
        n = 0;
        while (!done && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk("R11 first paddr", paddr, 32'h0ABC_DABC);
        req_valid = 1'b0;
        dn = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (done || fault) dn++;
        end
        chk("R11 extra pulses", dn, 0);
        chk("R11 txn", txn_cnt, 2);
    endtask

    initial begin
        mem_model[32'h0010_0004] = 32'h0020_0027;
        mem_model[32'h0020_000C] = 32'h0ABC_D067;
        mem_model[32'h0010_0008] = 32'h0030_0007;
        mem_model[32'h0030_0004] = 32'h0555_5007;
        mem_model[32'h0030_0008] = 32'h0555_5007;
        mem_model[32'h0010_00C0] = 32'h1F80_00A7;
        mem_model[32'h0020_0018] = 32'h0070_0021;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_small_read();
        t_small_write_dirty_set();
        t_accessed_wb();
        t_large();
        t_dir_absent();
        t_tbl_absent();
        t_clean_readonly_write();
        t_perm_sweep();
        t_busy_ignore();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule